// File: doc/BRIEF.md
# FIFO Threshold Offset Register Access

This block keeps the two threshold offsets of a FIFO: the almost-empty distance and the almost-full distance. Both are reached through the FIFO's own data paths. It does not need a separate configuration port. A load-select input changes what an enabled access does. While load-select is high, an enabled write-clock cycle stores the low eight bits of the write data into one offset byte, and no word goes into FIFO storage. While load-select is high, an enabled read-clock cycle places one offset byte in the output register instead of a FIFO word. Neither access moves the FIFO's own pointers.

Each offset is `OFS_W` bits wide, from 8 to 13 bits, so it is split into a low byte and a high byte. Each side has a sequencer that walks four slots in a fixed order: `SLOT_E_LO` (empty offset, bits 7:0), `SLOT_E_HI` (empty offset, upper bits), `SLOT_F_LO` (full offset, bits 7:0) and `SLOT_F_HI` (full offset, upper bits). Each sequencer has three transitions. ADVANCE moves to the next slot on an enabled load-select access. WRAP is the ADVANCE from `SLOT_F_HI` back to `SLOT_E_LO`. HOLD keeps the current slot when there is no such access. The write sequencer and the read sequencer move independently of each other. A load that stops partway continues from the same slot later. Reset returns both sequencers to `SLOT_E_LO` and sets both offsets to `DEPTH/8 - 1`. The offsets are expected to be loaded while the read side is idle. The read side samples them as quasi-static values.

Top module: `fifo_ofs_regs`

## Requirements
- R1: After reset, both offsets equal DEPTH/8-1 (127 for the default DEPTH of 1024), both sequencers are in SLOT_E_LO, and the output register q is zero.
- R2: When ld=1 and wen=1 at a rising wclk, din[7:0] is stored into the slot the write sequencer is in. The slot order is empty low byte, empty high byte, full low byte, full high byte.
- R3: The write sequencer advances by one slot per ld&wen edge and wraps from the full high byte to the empty low byte.
- R4: A high-byte write keeps only bits OFS_W-9:0 of din[7:0]. The remaining bits are discarded, and the offset never holds bits at or above OFS_W.
- R5: When ld=1 and ren=1 at a rising rclk, q takes the byte of the slot the read sequencer is in, in the same order as R2. Unused high bits read as zero, and q bits above 7 are zero.
- R6: The read sequencer advances by one slot per ld&ren edge, wraps after the full high byte, and is independent of the write sequencer.
- R7: With ld=0, neither sequencer moves, so a later load or readback resumes at the slot where it stopped.
- R8: fifo_we is high exactly when wen=1 and ld=0. fifo_re is high exactly when ren=1 and ld=0. Load-select accesses never reach the FIFO pointers.
- R9: When ren=1 and ld=0 at a rising rclk, q takes fifo_rdata. When ren=0, q holds its value.
- R10: An rising wclk edge without both ld and wen leaves both offsets unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld | input | 1 | Load-select: routes enabled accesses to the offset registers |
| wen | input | 1 | Write enable |
| ren | input | 1 | Read enable |
| din | input | DATA_W | Write data; bits 7:0 carry offset bytes |
| fifo_rdata | input | DATA_W | Word presented by FIFO storage |
| fifo_we | output | 1 | Write strobe to FIFO storage and write pointer |
| fifo_re | output | 1 | Read strobe to FIFO storage and read pointer |
| q | output | DATA_W | Registered read data |
| empty_ofs | output | OFS_W | Almost-empty threshold offset |
| full_ofs | output | OFS_W | Almost-full threshold offset |

## Verification
Some behaviours are checked by assertions on every edge of their own clock:
- each sequencer advances by exactly one slot on an enabled load-select access and otherwise holds;
- the offsets do not change without a load-select write;
- q holds when reads are disabled;
- load-select masks both FIFO strobes;
- q bits above 7 are zero after a readback.

The bench scenarios show the rest:
- which byte lands in which offset;
- the discarding of unused high bits;
- the byte order of a readback;
- the resumption of a partial sequence after a pause;
- the independence of the read and write sequencers.

// File: rtl/fifo_ofs_pkg.sv
package fifo_ofs_pkg;

    typedef enum logic [1:0] {
        SLOT_E_LO = 2'd0,
        SLOT_E_HI = 2'd1,
        SLOT_F_LO = 2'd2,
        SLOT_F_HI = 2'd3
    } slot_e;

    function automatic slot_e slot_after(slot_e s);
        slot_e n;
        unique case (s)
            SLOT_E_LO: n = SLOT_E_HI;
            SLOT_E_HI: n = SLOT_F_LO;
            SLOT_F_LO: n = SLOT_F_HI;
            SLOT_F_HI: n = SLOT_E_LO;
            default:   n = SLOT_E_LO;
        endcase
        return n;
    endfunction

    function automatic logic is_high_slot(slot_e s);
        return (s == SLOT_E_HI) || (s == SLOT_F_HI);
    endfunction

    function automatic logic is_full_slot(slot_e s);
        return (s == SLOT_F_LO) || (s == SLOT_F_HI);
    endfunction

endpackage

// File: rtl/fifo_ofs_wr_seq.sv
module fifo_ofs_wr_seq
    import fifo_ofs_pkg::*;
#(
    parameter int OFS_W   = 10,
    parameter int DEFAULT = 127
) (
    input  logic             wclk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic [7:0]       byte_in,
    output logic [OFS_W-1:0] empty_ofs,
    output logic [OFS_W-1:0] full_ofs,
    output logic [1:0]       pos
);

    localparam logic [OFS_W-1:0] RST_VAL = OFS_W'(DEFAULT);

    slot_e state, state_nxt;

    function automatic logic [OFS_W-1:0] merge(logic [OFS_W-1:0] cur,
                                               logic [7:0] b, logic hi);
        logic [15:0] ext;
        logic [15:0] nv;
        ext = 16'(cur);
        nv  = hi ? {b, ext[7:0]} : {ext[15:8], b};
        return nv[OFS_W-1:0];
    endfunction

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) state <= SLOT_E_LO;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = acc ? slot_after(state) : state;
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            empty_ofs <= RST_VAL;
            full_ofs  <= RST_VAL;
        end else if (acc) begin
            unique case (state)
                SLOT_E_LO, SLOT_E_HI:
                    empty_ofs <= merge(empty_ofs, byte_in, is_high_slot(state));
                SLOT_F_LO, SLOT_F_HI:
                    full_ofs  <= merge(full_ofs, byte_in, is_high_slot(state));
                default: ;
            endcase
        end
    end

    assign pos = state;

endmodule

// File: rtl/fifo_ofs_rd_seq.sv
module fifo_ofs_rd_seq
    import fifo_ofs_pkg::*;
#(
    parameter int OFS_W  = 10,
    parameter int DATA_W = 9
) (
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic              ren,
    input  logic [OFS_W-1:0]  empty_ofs,
    input  logic [OFS_W-1:0]  full_ofs,
    input  logic [DATA_W-1:0] fifo_rdata,
    output logic [DATA_W-1:0] q,
    output logic [1:0]        pos
);

    slot_e       state, state_nxt;
    logic        acc;
    logic [15:0] src;
    logic [7:0]  sel_byte;

    assign acc = ld && ren;

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) state <= SLOT_E_LO;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = acc ? slot_after(state) : state;
        src       = is_full_slot(state) ? 16'(full_ofs) : 16'(empty_ofs);
        sel_byte  = is_high_slot(state) ? src[15:8] : src[7:0];
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (ren)  q <= ld ? DATA_W'(sel_byte) : fifo_rdata;
    end

    assign pos = state;

endmodule

// File: rtl/fifo_ofs_regs.sv
module fifo_ofs_regs #(
    parameter int DEPTH  = 1024,
    parameter int OFS_W  = 10,
    parameter int DATA_W = 9
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic              wen,
    input  logic              ren,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] fifo_rdata,
    output logic              fifo_we,
    output logic              fifo_re,
    output logic [DATA_W-1:0] q,
    output logic [OFS_W-1:0]  empty_ofs,
    output logic [OFS_W-1:0]  full_ofs
);

    localparam int DEF_OFS = DEPTH / 8 - 1;

    logic [1:0] wr_pos;
    logic [1:0] rd_pos;

    assign fifo_we = wen && !ld;
    assign fifo_re = ren && !ld;

    fifo_ofs_wr_seq #(.OFS_W(OFS_W), .DEFAULT(DEF_OFS)) u_wr (
        .wclk      (wclk),
        .rst_n     (rst_n),
        .acc       (ld && wen),
        .byte_in   (din[7:0]),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs),
        .pos       (wr_pos)
    );

    fifo_ofs_rd_seq #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_rd (
        .rclk       (rclk),
        .rst_n      (rst_n),
        .ld         (ld),
        .ren        (ren),
        .empty_ofs  (empty_ofs),
        .full_ofs   (full_ofs),
        .fifo_rdata (fifo_rdata),
        .q          (q),
        .pos        (rd_pos)
    );

endmodule

// File: rtl/fifo_ofs_regs_chk.sv
module fifo_ofs_regs_chk #(
    parameter int OFS_W  = 10,
    parameter int DATA_W = 9
) (
    input logic              wclk,
    input logic              rclk,
    input logic              rst_n,
    input logic              ld,
    input logic              wen,
    input logic              ren,
    input logic              fifo_we,
    input logic              fifo_re,
    input logic [DATA_W-1:0] q,
    input logic [OFS_W-1:0]  empty_ofs,
    input logic [OFS_W-1:0]  full_ofs,
    input logic [1:0]        wr_pos,
    input logic [1:0]        rd_pos
);

    // R3
    p_wr_advance_r3: assert property (@(posedge wclk) disable iff (!rst_n)
        (ld && wen) |=> (wr_pos == 2'($past(wr_pos) + 2'd1)));

    // R7
    p_wr_hold_r7: assert property (@(posedge wclk) disable iff (!rst_n)
        !(ld && wen) |=> $stable(wr_pos));

    // R6
    p_rd_advance_r6: assert property (@(posedge rclk) disable iff (!rst_n)
        (ld && ren) |=> (rd_pos == 2'($past(rd_pos) + 2'd1)));

    // R7
    p_rd_hold_r7: assert property (@(posedge rclk) disable iff (!rst_n)
        !(ld && ren) |=> $stable(rd_pos));

    // R10
    p_ofs_stable_r10: assert property (@(posedge wclk) disable iff (!rst_n)
        !(ld && wen) |=> ($stable(empty_ofs) && $stable(full_ofs)));

    // R9
    p_q_hold_r9: assert property (@(posedge rclk) disable iff (!rst_n)
        !ren |=> $stable(q));

    // R8
    p_ld_masks_r8: assert property (@(posedge wclk) disable iff (!rst_n)
        ld |-> (!fifo_we && !fifo_re));

    generate
        if (DATA_W > 8) begin : g_upper
            // R5
            p_q_upper_zero_r5: assert property (@(posedge rclk) disable iff (!rst_n)
                (ld && ren) |=> (q[DATA_W-1:8] == '0));
        end
    endgenerate

endmodule

bind fifo_ofs_regs fifo_ofs_regs_chk #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_chk (
    .wclk      (wclk),
    .rclk      (rclk),
    .rst_n     (rst_n),
    .ld        (ld),
    .wen       (wen),
    .ren       (ren),
    .fifo_we   (fifo_we),
    .fifo_re   (fifo_re),
    .q         (q),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs),
    .wr_pos    (wr_pos),
    .rd_pos    (rd_pos)
);

// File: tb/fifo_ofs_regs_tb.sv
`timescale 1ns/1ps
module fifo_ofs_regs_tb;

    localparam int DEPTH  = 1024;
    localparam int OFS_W  = 10;
    localparam int DATA_W = 9;
    localparam int MASK   = (1 << OFS_W) - 1;

    logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
    logic ld = 1'b0, wen = 1'b0, ren = 1'b0;
    logic [DATA_W-1:0] din = '0, fifo_rdata = '0;
    logic fifo_we, fifo_re;
    logic [DATA_W-1:0] q;
    logic [OFS_W-1:0] empty_ofs, full_ofs;

    int n_chk = 0, n_err = 0;
    int m_e, m_f, m_wp, m_rp, m_q;
    bit done = 0;

    always #10 wclk = ~wclk;
    initial begin
        #5;
        forever #10 rclk = ~rclk;
    end

    fifo_ofs_regs #(.DEPTH(DEPTH), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_dut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .ld(ld), .wen(wen), .ren(ren),
        .din(din), .fifo_rdata(fifo_rdata), .fifo_we(fifo_we), .fifo_re(fifo_re),
        .q(q), .empty_ofs(empty_ofs), .full_ofs(full_ofs)
    );

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int put(int cur, int b, int slot);
        if (slot % 2 == 1) return ((cur & 'hFF) | ((b & 'hFF) << 8)) & MASK;
        return ((cur & ~'hFF) | (b & 'hFF)) & MASK;
    endfunction

    function automatic int get(int slot);
        int v;
        v = (slot >= 2) ? m_f : m_e;
        return (slot % 2 == 1) ? ((v >> 8) & 'hFF) : (v & 'hFF);
    endfunction

    task automatic wr(bit l, bit e, int d, string req);
        ld = l; wen = e; din = DATA_W'(d);
        #1;
        check(fifo_we == (e && !l), "R8 fifo_we", int'(fifo_we), int'(e && !l));
        @(posedge wclk); #2;
        if (l && e) begin
            if (m_wp < 2) m_e = put(m_e, d, m_wp);
            else          m_f = put(m_f, d, m_wp);
            m_wp = (m_wp + 1) % 4;
        end
        check(int'(empty_ofs) == m_e, {req, " empty_ofs"}, int'(empty_ofs), m_e);
        check(int'(full_ofs) == m_f, {req, " full_ofs"}, int'(full_ofs), m_f);
        ld = 0; wen = 0;
    endtask

    task automatic rd(bit l, bit e, int fd, string req);
        ld = l; ren = e; fifo_rdata = DATA_W'(fd);
        #1;
        check(fifo_re == (e && !l), "R8 fifo_re", int'(fifo_re), int'(e && !l));
        @(posedge rclk); #2;
        if (e) begin
            if (l) begin m_q = get(m_rp); m_rp = (m_rp + 1) % 4; end
            else m_q = fd;
        end
        check(int'(q) == m_q, {req, " q"}, int'(q), m_q);
        ld = 0; ren = 0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        m_e = DEPTH / 8 - 1; m_f = DEPTH / 8 - 1; m_wp = 0; m_rp = 0; m_q = 0;
        #53 rst_n = 1'b1;
        @(negedge wclk);
        // R1 reset state
        check(int'(empty_ofs) == 127, "R1 empty_ofs", int'(empty_ofs), 127);
        check(int'(full_ofs) == 127, "R1 full_ofs", int'(full_ofs), 127);
        check(q == '0, "R1 q", int'(q), 0);
        // R1 readback of defaults starts at empty low byte
        rd(1, 1, 0, "R1 default readback");
        rd(1, 1, 0, "R1 default readback hi");
        rd(1, 1, 0, "R5 full lo");
        rd(1, 1, 0, "R6 full hi then wrap");
        // R2/R4 load sequence; high byte 0xFF truncated to 2 bits
        wr(1, 1, 'h134, "R2 empty lo");
        wr(1, 1, 'hFF,  "R4 empty hi truncate");
        wr(1, 1, 'h56,  "R2 full lo");
        wr(1, 1, 'h01,  "R2 full hi");
        check(int'(empty_ofs) == 'h334, "R4 empty_ofs value", int'(empty_ofs), 'h334);
        check(int'(full_ofs) == 'h156, "R2 full_ofs value", int'(full_ofs), 'h156);
        // R10 ld without wen, wen without ld
        wr(1, 0, 'hAA, "R10 ld only");
        wr(0, 1, 'hAA, "R10 wen only");
        // R5 readback in order
        rd(1, 1, 'h1FF, "R5 empty lo");
        rd(1, 1, 'h1FF, "R5 empty hi unused zero");
        rd(1, 1, 'h1FF, "R5 full lo");
        rd(1, 1, 'h1FF, "R5 full hi");
        // R3 wrap on write side
        wr(1, 1, 'h11, "R3 wrap to empty lo");
        // R7 pause then resume at empty hi
        wr(0, 1, 'h77, "R7 pause");
        wr(0, 0, 'h77, "R7 idle");
        wr(1, 1, 'h02, "R7 resume empty hi");
        check(int'(empty_ofs) == 'h211, "R7 empty_ofs value", int'(empty_ofs), 'h211);
        // R6 read side independent, wraps to empty lo
        rd(1, 1, 0, "R6 wrap empty lo");
        check(int'(q) == 'h11, "R6 q value", int'(q), 'h11);
        // R9 FIFO data path and hold
        rd(0, 1, 'h1A5, "R9 fifo data");
        rd(0, 0, 'h05A, "R9 hold");
        rd(1, 0, 'h05A, "R9 ld hold");
        // R7 read resumes at empty hi
        rd(1, 1, 0, "R7 read resume empty hi");
        check(int'(q) == 'h02, "R7 q value", int'(q), 'h02);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule